// File: doc/BRIEF.md
# Bit-Serial Test Pattern Generator and Checker

This block drives a test pattern onto one serial tributary and checks a pattern arriving on another. Both directions advance only on cycles where the bit-enable input is high, so the block runs at any line rate derived from the core clock. The stream is unframed. A single pattern-select input sets both the generator and the expected pattern in the checker. The selectable patterns are three maximal-length pseudorandom sequences, a quasi-random variant of the 20-stage sequence, a 1/0 toggle, steady ones, and a 16-bit word supplied by the user. A one-cycle pulse flips exactly one outgoing bit.

The checker is a two-state machine. In ST_SEARCH it shifts received bits into its own history register, so it aligns to the incoming sequence without a seed. It takes the transition SEARCH→LOCKED after 32 consecutive bits that match its prediction. In ST_LOCKED it feeds its own predictions back, so a line error costs one count only. It counts mismatches in a saturating counter. It takes the transition LOCKED→SEARCH when six or more mismatches fall inside one 64-bit window. Long runs of ones (an alarm-indication stream) and long runs of zeros (an idle line) are each flagged. A loss of lock can raise an interrupt, and status can also be polled; reading the counter also clears the interrupt.

Top module: `tpat_engine`

## Requirements
- R1: After reset, tx_bit, in_sync, err_count, irq, ais_det and idle_det are all 0. The generator history is all ones and the user-word phase is 0.
- R2: pat_sel 1, 2 and 3 give the sequences x^15+x^14+1, x^20+x^3+1 and x^23+x^18+1. Each new bit is the XOR of the bits 15 and 14 back (code 1), 20 and 3 back (code 2) or 23 and 18 back (code 3) in the unforced stream. Before the first bit, the history holds all ones.
- R3: pat_sel 0 gives the 20-stage sequence, except that an output bit is forced to 1 when the 14 or more output bits before it were all 0. Forcing does not alter the sequence history.
- R4: pat_sel 4 outputs the inverse of the previous history bit. pat_sel 5 and 7 output steady ones. pat_sel 6 outputs user_word bit (15 − phase), where phase is a 4-bit counter that advances on every enabled bit.
- R5: When a pseudorandom code is selected and the stages it uses are all zero, the history is replaced by all ones before the bit is computed.
- R6: A one-cycle inj_err pulse inverts exactly one output bit: the next one produced.
- R7: While bit_en is low, tx_bit, the checker state and the run flags hold.
- R8: The checker enters lock only after 32 consecutive matching bits.
- R9: Mismatches are counted only while locked. The counter saturates at 2^CNT_W − 1.
- R10: A cnt_rd pulse clears err_count. An error in the same cycle leaves the count at 1.
- R11: Six or more mismatches inside one aligned 64-bit window drop lock. Five in a row keep lock.
- R12: irq is set on loss of lock, is masked by irq_en, and is cleared by cnt_rd.
- R13: ais_det is set after 32 consecutive received ones and idle_det after 32 consecutive zeros. Each clears on the opposite bit.
- R14: With pat_sel 6, the checker predicts each bit as the one received 16 bits earlier, so it locks to any user word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable for both directions |
| pat_sel | input | 3 | Pattern code (see R2 to R4) |
| user_word | input | 16 | Repeating user word, MSB first |
| inj_err | input | 1 | Single-bit error request pulse |
| tx_bit | output | 1 | Generated serial bit |
| rx_bit | input | 1 | Received serial bit |
| irq_en | input | 1 | Interrupt mask, 1 = enabled |
| cnt_rd | input | 1 | Counter read strobe: clears the count and the interrupt |
| err_count | output | CNT_W | Saturating mismatch count |
| in_sync | output | 1 | Checker is in ST_LOCKED |
| ais_det | output | 1 | All-ones run detected |
| idle_det | output | 1 | All-zeros run detected |
| irq | output | 1 | Loss-of-lock interrupt |

## Verification
The bench aims at the edges of the checker's thresholds and at pattern switches. It injects five consecutive errors, which must not drop lock, and twelve, which must; a checker whose window does not clear would drop lock on errors spread over time. It switches from an all-zero user word into the quasi-random and 15-stage codes. A missing zero guard would lock the generator at zero, and a forced-one rule that ignores earlier zeros would emit 0 on the first bit. It also drives the counter into saturation, which exposes a counter that wraps, and it locks onto a user word, which exposes a checker that predicts only the pseudorandom codes.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int HIST_W = 23;

    typedef enum logic [2:0] {
        PAT_QRSS = 3'd0,
        PAT_P15  = 3'd1,
        PAT_P20  = 3'd2,
        PAT_P23  = 3'd3,
        PAT_ALT  = 3'd4,
        PAT_ONES = 3'd5,
        PAT_USER = 3'd6,
        PAT_RSVD = 3'd7
    } pat_e;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } mon_st_e;

    function automatic logic uses_lfsr(pat_e p);
        return (p == PAT_QRSS) || (p == PAT_P15) || (p == PAT_P20) || (p == PAT_P23);
    endfunction

    // feedback bit of the selected polynomial, history bit 0 is the newest
    function automatic logic prbs_fb(pat_e p, logic [HIST_W-1:0] h);
        case (p)
            PAT_P15: return h[14] ^ h[13];
            PAT_P23: return h[22] ^ h[17];
            default: return h[19] ^ h[2];
        endcase
    endfunction

    function automatic logic lfsr_dead(pat_e p, logic [HIST_W-1:0] h);
        case (p)
            PAT_P15: return h[14:0] == 15'd0;
            PAT_P23: return h == '0;
            default: return h[19:0] == 20'd0;
        endcase
    endfunction

endpackage

// File: rtl/tpat_gen.sv
module tpat_gen
    import tpat_pkg::*;
#(
    parameter int QZ_MAX = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  pat_e        pat,
    input  logic [15:0] user_word,
    input  logic        inj_err,
    output logic        tx_bit
);
    localparam int ZW = $clog2(QZ_MAX + 2);

    logic [HIST_W-1:0] hist, hist_eff;
    logic [ZW-1:0]     zrun;
    logic [3:0]        phase;
    logic              pend, lbit, raw;

    always_comb begin
        hist_eff = (uses_lfsr(pat) && lfsr_dead(pat, hist)) ? '1 : hist;
        case (pat)
            PAT_QRSS, PAT_P15, PAT_P20, PAT_P23: lbit = prbs_fb(pat, hist_eff);
            PAT_ALT:  lbit = ~hist_eff[0];
            PAT_USER: lbit = user_word[4'd15 - phase];
            default:  lbit = 1'b1;
        endcase
        raw = ((pat == PAT_QRSS) && (zrun >= ZW'(QZ_MAX))) ? 1'b1 : lbit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist   <= '1;
            zrun   <= '0;
            phase  <= '0;
            pend   <= 1'b0;
            tx_bit <= 1'b0;
        end else if (bit_en) begin
            hist   <= {hist_eff[HIST_W-2:0], lbit};
            zrun   <= raw ? '0 : ((zrun == '1) ? zrun : zrun + 1'b1);
            phase  <= phase + 1'b1;
            tx_bit <= raw ^ (pend | inj_err);
            pend   <= 1'b0;
        end else if (inj_err) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/tpat_mon.sv
module tpat_mon
    import tpat_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_RUN = 32,
    parameter int WIN      = 64,
    parameter int LOSS_ERR = 6,
    parameter int RUN_LEN  = 32,
    parameter int QZ_MAX   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  pat_e             pat,
    input  logic             rx_bit,
    input  logic             irq_en,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] err_count,
    output logic             in_sync,
    output logic             ais_det,
    output logic             idle_det,
    output logic             irq
);
    localparam int RUN_W = $clog2(SYNC_RUN + 1);
    localparam int WIN_W = $clog2(WIN);
    localparam int LE_W  = $clog2(LOSS_ERR + 1);
    localparam int AR_W  = $clog2(RUN_LEN + 1);
    localparam int ZW    = $clog2(QZ_MAX + 2);

    mon_st_e           state, state_nx;
    logic [HIST_W-1:0] hist;
    logic [ZW-1:0]     zrun;
    logic [RUN_W-1:0]  good_run;
    logic [WIN_W-1:0]  win_pos;
    logic [LE_W-1:0]   win_err;
    logic [AR_W-1:0]   one_run, zero_run;
    logic [CNT_W-1:0]  cnt;
    logic              irq_flag;
    logic              exp_l, exp_b, mism, hit_err, lose, z_in;

    // prediction of the next received bit
    always_comb begin
        case (pat)
            PAT_QRSS, PAT_P15, PAT_P20, PAT_P23: exp_l = prbs_fb(pat, hist);
            PAT_ALT:  exp_l = ~hist[0];
            PAT_USER: exp_l = hist[15];
            default:  exp_l = 1'b1;
        endcase
        exp_b   = ((pat == PAT_QRSS) && (zrun >= ZW'(QZ_MAX))) ? 1'b1 : exp_l;
        mism    = rx_bit ^ exp_b;
        hit_err = bit_en && (state == ST_LOCKED) && mism;
        lose    = hit_err && ((int'(win_err) + 1) >= LOSS_ERR);
        z_in    = (state == ST_LOCKED) ? exp_b : rx_bit;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SEARCH: if (bit_en && !mism && (int'(good_run) == SYNC_RUN - 1)) state_nx = ST_LOCKED;
            ST_LOCKED: if (lose) state_nx = ST_SEARCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SEARCH;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist     <= '0;
            zrun     <= '0;
            good_run <= '0;
            win_pos  <= '0;
            win_err  <= '0;
            one_run  <= '0;
            zero_run <= '0;
        end else if (bit_en) begin
            hist <= {hist[HIST_W-2:0], (state == ST_LOCKED) ? exp_l : rx_bit};
            zrun <= z_in ? '0 : ((zrun == '1) ? zrun : zrun + 1'b1);
            if ((state == ST_LOCKED) || mism || (state_nx == ST_LOCKED))
                good_run <= '0;
            else
                good_run <= good_run + 1'b1;
            if ((state == ST_LOCKED) && (state_nx == ST_LOCKED)) begin
                if (int'(win_pos) == WIN - 1) begin
                    win_pos <= '0;
                    win_err <= '0;
                end else begin
                    win_pos <= win_pos + 1'b1;
                    win_err <= win_err + LE_W'(mism);
                end
            end else begin
                win_pos <= '0;
                win_err <= '0;
            end
            one_run  <= !rx_bit ? '0 : ((one_run  == AR_W'(RUN_LEN)) ? one_run  : one_run  + 1'b1);
            zero_run <=  rx_bit ? '0 : ((zero_run == AR_W'(RUN_LEN)) ? zero_run : zero_run + 1'b1);
        end
    end

    // error counter and interrupt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (cnt_rd)
                cnt <= hit_err ? CNT_W'(1) : '0;
            else if (hit_err && (cnt != '1))
                cnt <= cnt + 1'b1;
            if ((state == ST_LOCKED) && (state_nx == ST_SEARCH))
                irq_flag <= 1'b1;
            else if (cnt_rd)
                irq_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        in_sync   = (state == ST_LOCKED);
        ais_det   = (one_run == AR_W'(RUN_LEN));
        idle_det  = (zero_run == AR_W'(RUN_LEN));
        irq       = irq_flag & irq_en;
        err_count = cnt;
    end

endmodule

// File: rtl/tpat_engine.sv
module tpat_engine
    import tpat_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_RUN = 32,
    parameter int WIN      = 64,
    parameter int LOSS_ERR = 6,
    parameter int RUN_LEN  = 32,
    parameter int QZ_MAX   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [2:0]       pat_sel,
    input  logic [15:0]      user_word,
    input  logic             inj_err,
    output logic             tx_bit,
    input  logic             rx_bit,
    input  logic             irq_en,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] err_count,
    output logic             in_sync,
    output logic             ais_det,
    output logic             idle_det,
    output logic             irq
);
    pat_e pat;
    assign pat = pat_e'(pat_sel);

    tpat_gen #(.QZ_MAX(QZ_MAX)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .pat       (pat),
        .user_word (user_word),
        .inj_err   (inj_err),
        .tx_bit    (tx_bit)
    );

    tpat_mon #(
        .CNT_W    (CNT_W),
        .SYNC_RUN (SYNC_RUN),
        .WIN      (WIN),
        .LOSS_ERR (LOSS_ERR),
        .RUN_LEN  (RUN_LEN),
        .QZ_MAX   (QZ_MAX)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .pat       (pat),
        .rx_bit    (rx_bit),
        .irq_en    (irq_en),
        .cnt_rd    (cnt_rd),
        .err_count (err_count),
        .in_sync   (in_sync),
        .ais_det   (ais_det),
        .idle_det  (idle_det),
        .irq       (irq)
    );

endmodule

// File: rtl/tpat_chk.sv
module tpat_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             cnt_rd,
    input logic             irq_en,
    input logic             tx_bit,
    input logic [CNT_W-1:0] err_count,
    input logic             in_sync,
    input logic             ais_det,
    input logic             idle_det,
    input logic             irq
);
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == {CNT_W{1'b1}} && !cnt_rd) |=> (err_count == {CNT_W{1'b1}})); // R9

    AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync && !cnt_rd) |=> $stable(err_count)); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |=> (err_count <= CNT_W'(1))); // R10

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(in_sync) && $stable(ais_det) && $stable(idle_det))); // R7

    AST_IRQ_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_sync) && irq_en) |-> irq); // R12

    AST_LOCK_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(bit_en)); // R8

    AST_RUNS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ais_det && idle_det)); // R13

endmodule

bind tpat_engine tpat_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .cnt_rd    (cnt_rd),
    .irq_en    (irq_en),
    .tx_bit    (tx_bit),
    .err_count (err_count),
    .in_sync   (in_sync),
    .ais_det   (ais_det),
    .idle_det  (idle_det),
    .irq       (irq)
);

// File: tb/sim_tpat_engine.sv
`timescale 1ns/1ps
module sim_tpat_engine;
    localparam int CW = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0, bit_en = 1'b1, inj = 1'b0, cnt_rd = 1'b0, irq_en = 1'b1;
    logic [2:0]    pat = 3'd1;
    logic [15:0]   uw = 16'hA5C3;
    logic          loop_en = 1'b1, force_v = 1'b0, flip = 1'b0;
    logic          tx, rx, in_sync, ais, idle, irq;
    logic [CW-1:0] cnt;

    assign rx = loop_en ? (tx ^ flip) : force_v;

    tpat_engine #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pat_sel(pat), .user_word(uw),
        .inj_err(inj), .tx_bit(tx), .rx_bit(rx), .irq_en(irq_en), .cnt_rd(cnt_rd),
        .err_count(cnt), .in_sync(in_sync), .ais_det(ais), .idle_det(idle), .irq(irq)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    // reference generator state
    logic [22:0] m_h;
    int          m_z, m_u;

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_h = '1; m_z = 0; m_u = 0;
    endtask

    task automatic m_next(input logic [2:0] p, output logic b);
        logic [22:0] he;
        logic lb;
        he = m_h;
        if (p <= 3'd3) begin
            if (p == 3'd1 && m_h[14:0] == 15'd0) he = '1;
            if (p == 3'd3 && m_h == 23'd0) he = '1;
            if ((p == 3'd0 || p == 3'd2) && m_h[19:0] == 20'd0) he = '1;
        end
        case (p)
            3'd1:       lb = he[14] ^ he[13];
            3'd3:       lb = he[22] ^ he[17];
            3'd0, 3'd2: lb = he[19] ^ he[2];
            3'd4:       lb = ~he[0];
            3'd6:       lb = uw[15 - m_u];
            default:    lb = 1'b1;
        endcase
        b   = (p == 3'd0 && m_z >= 14) ? 1'b1 : lb;
        m_h = {he[21:0], lb};
        m_z = b ? 0 : ((m_z < 15) ? m_z + 1 : 15);
        m_u = (m_u + 1) % 16;
    endtask

    task automatic gen_seg(input int n, input string req, input string what);
        int bad = 0, ones = 0;
        logic e;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            m_next(pat, e);
            if (tx !== e) bad++;
            if (tx === 1'b1) ones++;
        end
        check(bad == 0, req, what, bad, 0);
        if (pat <= 3'd3) check(ones > 0, "R5", "ones seen in pseudorandom segment", ones, 1);
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ticks(3);
        check(tx == 1'b0 && in_sync == 1'b0 && cnt == '0 && irq == 1'b0 && ais == 1'b0 && idle == 1'b0,
              "R1", "outputs in reset", {tx, in_sync, cnt, irq, ais, idle}, 0);
        rst_n = 1'b1;
        m_reset();
    endtask

    task automatic read_cnt();
        cnt_rd = 1'b1;
        ticks(1);
        cnt_rd = 1'b0;
    endtask

    task automatic inject_one();
        inj = 1'b1;
        ticks(1);
        inj = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic e, t0;
        int bad, min_sync;
        ticks(1);
        do_reset();

        // generator sweep over every code
        pat = 3'd1; gen_seg(600, "R2", "PRBS15 sequence");
        pat = 3'd2; gen_seg(600, "R2", "PRBS20 sequence");
        pat = 3'd3; gen_seg(600, "R2", "PRBS23 sequence");
        pat = 3'd0; gen_seg(600, "R3", "QRSS sequence");
        pat = 3'd4; gen_seg(64,  "R4", "alternating");
        pat = 3'd5; gen_seg(64,  "R4", "all ones");
        pat = 3'd7; gen_seg(32,  "R4", "reserved code as ones");
        pat = 3'd6; gen_seg(80,  "R4", "user word A5C3");
        uw = 16'h8001; gen_seg(48, "R4", "user word 8001");

        // zero run then quasi-random: first bit forced to one
        uw = 16'h0000; pat = 3'd6; gen_seg(30, "R4", "user word zero");
        pat = 3'd0;
        @(negedge clk); m_next(pat, e);
        check(tx === 1'b1 && e === 1'b1, "R3", "first QRSS bit after zero run", tx, 1);
        gen_seg(300, "R3", "QRSS after reload");

        // zero history then 15-stage code: guard reload
        pat = 3'd6; gen_seg(30, "R4", "user word zero again");
        pat = 3'd1; gen_seg(200, "R5", "PRBS15 after zero history");

        // single error injection
        pat = 3'd3; gen_seg(20, "R2", "PRBS23 before inject");
        inj = 1'b1;
        @(negedge clk); m_next(pat, e); inj = 1'b0;
        check(tx === ~e, "R6", "injected bit inverted", tx, ~e);
        gen_seg(50, "R6", "no further inversion");
        pat = 3'd4; gen_seg(10, "R4", "alternating before inject");
        inj = 1'b1;
        @(negedge clk); m_next(pat, e); inj = 1'b0;
        check(tx === ~e, "R6", "injected bit on alternating", tx, ~e);

        // hold while enable low
        pat = 3'd2; gen_seg(40, "R2", "PRBS20 before hold");
        bit_en = 1'b0; t0 = tx; bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tx !== t0) bad++;
        end
        check(bad == 0, "R7", "tx held while disabled", bad, 0);
        bit_en = 1'b1;
        gen_seg(60, "R7", "sequence resumes without skip");

        // checker: acquisition
        uw = 16'hA5C3; pat = 3'd1;
        do_reset();
        ticks(31);
        check(in_sync == 1'b0, "R8", "not locked before 32 bits", in_sync, 0);
        ticks(60);
        check(in_sync == 1'b1, "R8", "locked on clean stream", in_sync, 1);
        read_cnt();
        ticks(100);
        check(cnt == 0, "R9", "no errors on clean stream", cnt, 0);

        // counting injected errors
        for (int k = 0; k < 3; k++) begin inject_one(); ticks(99); end
        check(cnt == 3, "R9", "three injected errors counted", cnt, 3);
        read_cnt();
        check(cnt == 0, "R10", "count cleared by read", cnt, 0);

        // five consecutive flips keep lock
        min_sync = 1;
        flip = 1'b1;
        for (int i = 0; i < 5; i++) begin ticks(1); if (!in_sync) min_sync = 0; end
        flip = 1'b0;
        for (int i = 0; i < 20; i++) begin ticks(1); if (!in_sync) min_sync = 0; end
        check(min_sync == 1, "R11", "lock kept with five errors", min_sync, 1);
        check(cnt == 5, "R9", "five flips counted", cnt, 5);
        check(irq == 1'b0, "R12", "no interrupt while locked", irq, 0);

        // twelve consecutive flips drop lock
        flip = 1'b1; ticks(12); flip = 1'b0;
        check(in_sync == 1'b0, "R11", "lock lost with twelve errors", in_sync, 0);
        check(irq == 1'b1, "R12", "interrupt on loss", irq, 1);
        irq_en = 1'b0; #1;
        check(irq == 1'b0, "R12", "interrupt masked", irq, 0);
        irq_en = 1'b1; #1;
        check(irq == 1'b1, "R12", "interrupt unmasked", irq, 1);
        ticks(1);
        read_cnt();
        check(irq == 1'b0, "R12", "interrupt cleared by read", irq, 0);
        ticks(150);
        check(in_sync == 1'b1, "R8", "relock after loss", in_sync, 1);

        // saturation
        read_cnt();
        for (int k = 0; k < 70; k++) begin inject_one(); ticks(69); end
        check(cnt == 6'd63, "R9", "counter saturates", cnt, 63);
        check(in_sync == 1'b1, "R11", "spread errors keep lock", in_sync, 1);
        read_cnt();
        check(cnt == 0, "R10", "saturated count cleared", cnt, 0);

        // checker on user word
        pat = 3'd6;
        ticks(150);
        check(in_sync == 1'b1, "R14", "locked on user word", in_sync, 1);
        read_cnt();
        for (int k = 0; k < 2; k++) begin inject_one(); ticks(79); end
        check(cnt == 2, "R14", "errors counted on user word", cnt, 2);

        // run detectors
        loop_en = 1'b0; force_v = 1'b1;
        ticks(28);
        check(ais == 1'b0, "R13", "no all-ones flag below threshold", ais, 0);
        ticks(12);
        check(ais == 1'b1 && idle == 1'b0, "R13", "all-ones flag", {ais, idle}, 2);
        force_v = 1'b0;
        ticks(1);
        check(ais == 1'b0, "R13", "all-ones flag cleared by zero", ais, 0);
        ticks(27);
        check(idle == 1'b0, "R13", "no idle flag below threshold", idle, 0);
        ticks(12);
        check(idle == 1'b1 && ais == 1'b0, "R13", "idle flag", {ais, idle}, 1);
        bit_en = 1'b0; force_v = 1'b1;
        ticks(5);
        check(idle == 1'b1, "R7", "idle flag held while disabled", idle, 1);
        bit_en = 1'b1;
        ticks(1);
        check(idle == 1'b0, "R13", "idle flag cleared by one", idle, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule